// File: doc/BRIEF.md
# Three-Wire Byte Transfer Handshake Engine

This block moves bytes between a host processor and a local controller over a byte-wide shift data register. The host owns two active-low handshake lines in a port register: an in-progress line and an acknowledge line. The controller owns one active-low request line in the same register. A direction bit in an auxiliary control register selects whether the host is sending or reading. Bytes are not clocked by a serial clock. Each change of the in-progress/acknowledge pair, while in-progress is low, moves exactly one byte.

Bytes the host sends are collected in a small buffer. When the host ends the transfer, a one-cycle packet strobe reports how many bytes arrived. The buffer stays readable by a local address port. The response path works the other way. A local port fills a response memory and then commits its length. The request line is driven low to announce the response, and each handshake edge delivers the next byte into the shift register. Every byte moved raises a shift-register flag. Command decoding is done elsewhere.

When no transfer is in progress, the request line echoes the acknowledge level, so the host can synchronise on the controller.

Top module: `hs_xfer_top`

## Requirements
- R1: After reset the port register reads 8'h38 (request bit 3, acknowledge bit 4 and in-progress bit 5 all high, meaning deasserted; other bits 0). The shift register reads 0, the flag is low and the packet strobe is low.
- R2: With auxiliary control bit 4 set (host sends) and in-progress (bit 5) low, each port write that changes bits {5,4} appends the shift register value to the collect buffer and raises the flag.
- R3: Once the collect buffer holds OUT_DEPTH (16) bytes, further handshake edges append nothing and raise no flag.
- R4: A port write that takes in-progress from low to high raises the flag. If the collect buffer holds at least one byte, the write also pulses pkt_valid for one cycle with pkt_len equal to the count, and the count returns to 0. The bytes remain readable at pkt_rd_addr, with byte 0 being the first byte sent.
- R5: Ending a transfer with an empty collect buffer still raises the flag but gives no packet strobe.
- R6: With auxiliary control bit 4 clear (host reads) and in-progress low, each change of bits {5,4} while response bytes are pending loads the next response byte into the shift register and raises the flag. With nothing pending, such an edge changes nothing.
- R7: Delivering the last pending response byte drives the request bit (bit 3) high.
- R8: With in-progress high both before and after a write, a change of the acknowledge bit copies its new level into the request bit and raises the flag.
- R9: Committing a response of nonzero length restarts delivery at byte 0, raises the flag, and, while in-progress is high, drives the request bit low.
- R10: A port write that leaves bits {5,4} unchanged while in-progress is low moves no byte.
- R11: Bit 3 of a host port write is ignored; the request bit is set only by the controller.
- R12: sr_clr clears the flag when no new event sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pb_wr | input | 1 | Host write strobe for the port register |
| pb_wdata | input | 8 | Host write data for the port register |
| pb_rdata | output | 8 | Port register readback, including the request bit |
| ctl_wr | input | 1 | Host write strobe for the auxiliary control register |
| ctl_wdata | input | 8 | Auxiliary control data (bit 4 = host sends) |
| sr_wr | input | 1 | Host write strobe for the shift register |
| sr_wdata | input | 8 | Host write data for the shift register |
| sr_rdata | output | 8 | Shift register value |
| sr_clr | input | 1 | Clears the shift-register flag |
| sr_flag | output | 1 | Shift-register event flag |
| rsp_wr | input | 1 | Local write strobe into the response memory |
| rsp_addr | input | 7 | Response memory write address |
| rsp_wdata | input | 8 | Response memory write data |
| rsp_load | input | 1 | Commits a response of rsp_len bytes |
| rsp_len | input | 8 | Response length, 0 to 128 |
| pkt_valid | output | 1 | One-cycle strobe: host packet received |
| pkt_len | output | 5 | Byte count of the received packet |
| pkt_rd_addr | input | 4 | Read address into the collect buffer |
| pkt_rd_data | output | 8 | Collect buffer byte at pkt_rd_addr |

## Verification
Each port write, response commit or flag clear is evaluated in the cycle it is presented. Its results appear one clock edge later: the port readback, shift register, flag and collect count all update on that edge, and the packet strobe is high for exactly that one cycle. The bench drives stimulus on falling edges and samples on the next falling edge, which is the first point where the registered result is due. A scoreboard queue holds the expected packet lengths, and a monitor pops the queue on every strobe, so any strobe that arrives early, extra or missing is caught.

// File: rtl/hs_xfer_pkg.sv
// Package: bit positions and the per-evaluation decision record shared by
// the handshake engine. Assumes an 8-bit port register.
package hs_xfer_pkg;
    localparam int REQ_BIT = 3;   // controller-driven, active low
    localparam int ACK_BIT = 4;   // host-driven, active low
    localparam int TIP_BIT = 5;   // host-driven, active low
    localparam int DIR_BIT = 4;   // auxiliary control: 1 = host sends
    localparam logic [7:0] PB_RESET = 8'h38;

    typedef struct packed {
        logic       append;  // push shift register into collect buffer
        logic       adv;     // deliver next response byte
        logic       flag;    // raise shift-register flag
        logic       pkt;     // host packet complete
        logic [7:0] nb;      // next port register value
    } eval_t;
endpackage

// File: rtl/hs_eval.sv
// Handshake evaluator: a purely combinational decision on one port update.
// It compares the incoming port value with the previous one and decides
// whether a byte moves, what the request bit becomes, and whether a packet ends.
// Assumes new_b already carries the controller-owned request bit.
module hs_eval
    import hs_xfer_pkg::*;
(
    input  logic       go,
    input  logic [7:0] old_b,
    input  logic [7:0] new_b,
    input  logic       dir_send,
    input  logic       pending,
    input  logic       last_one,
    input  logic       out_room,
    input  logic       out_nonempty,
    output eval_t      res
);
    logic pair_changed;
    assign pair_changed = {new_b[TIP_BIT], new_b[ACK_BIT]} != {old_b[TIP_BIT], old_b[ACK_BIT]};

    // Decide the effect of one evaluation.
    always_comb begin
        res    = '0;
        res.nb = new_b;
        if (go) begin
            if (!new_b[TIP_BIT]) begin
                if (pair_changed) begin
                    if (dir_send) begin
                        if (out_room) begin
                            res.append = 1'b1;
                            res.flag   = 1'b1;
                        end
                    end else if (pending) begin
                        res.adv  = 1'b1;
                        res.flag = 1'b1;
                        if (last_one) res.nb[REQ_BIT] = 1'b1;
                    end
                end
            end else if (old_b[TIP_BIT] && (new_b[ACK_BIT] != old_b[ACK_BIT])) begin
                res.nb[REQ_BIT] = new_b[ACK_BIT];
                res.flag        = 1'b1;
            end else begin
                if (!old_b[TIP_BIT]) begin
                    res.flag = 1'b1;
                    res.pkt  = out_nonempty;
                end
                if (pending) res.nb[REQ_BIT] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/hs_out_buf.sv
// Collect buffer for host-sent bytes: appends at the count, clears the count
// at packet end, and stays readable by address. Assumes push and clear never coincide.
module hs_out_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          clear,
    output logic [CW-1:0] count,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    // Track how many bytes are held.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= '0;
        else if (push && count < CW'(DEPTH)) count <= count + 1'b1;
    end

    // Store the appended byte.
    always_ff @(posedge clk) begin
        if (push && count < CW'(DEPTH)) mem[count[AW-1:0]] <= din;
    end

    assign rd_data = mem[rd_addr];

    // R3
    out_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/hs_rsp_buf.sv
// Response memory and delivery index: the local side writes bytes and commits
// a length; each advance hands out the next byte. Assumes len <= DEPTH.
module hs_rsp_buf #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int IW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          load,
    input  logic [IW-1:0] len,
    input  logic          adv,
    output logic [W-1:0]  cur_byte,
    output logic          pending,
    output logic          last_one
);
    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] idx, len_q;
    logic [IW-1:0] idx_eff, len_eff;

    // Store response bytes from the local side.
    always_ff @(posedge clk) begin
        if (wr) mem[waddr] <= wdata;
    end

    // Restart on commit, step on each delivered byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            len_q <= '0;
        end else if (load) begin
            len_q <= len;
            idx   <= adv ? IW'(1) : '0;
        end else if (adv) begin
            idx <= idx + 1'b1;
        end
    end

    assign idx_eff  = load ? '0  : idx;
    assign len_eff  = load ? len : len_q;
    assign pending  = idx_eff < len_eff;
    assign last_one = (idx_eff + 1'b1) >= len_eff;
    assign cur_byte = mem[idx_eff[AW-1:0]];

    // R6
    rd_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= len_q);
endmodule

// File: rtl/hs_xfer_top.sv
// Three-wire byte transfer engine top: holds the port, control and shift
// registers and the flag, and wires the evaluator to both buffers.
// Assumes a host write and a response commit are evaluated together when they coincide.
module hs_xfer_top
    import hs_xfer_pkg::*;
#(
    parameter int OUT_DEPTH = 16,
    parameter int RSP_DEPTH = 128,
    localparam int LW  = $clog2(OUT_DEPTH + 1),
    localparam int OAW = $clog2(OUT_DEPTH),
    localparam int RAW = $clog2(RSP_DEPTH),
    localparam int RIW = $clog2(RSP_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pb_wr,
    input  logic [7:0]     pb_wdata,
    output logic [7:0]     pb_rdata,
    input  logic           ctl_wr,
    input  logic [7:0]     ctl_wdata,
    input  logic           sr_wr,
    input  logic [7:0]     sr_wdata,
    output logic [7:0]     sr_rdata,
    input  logic           sr_clr,
    output logic           sr_flag,
    input  logic           rsp_wr,
    input  logic [RAW-1:0] rsp_addr,
    input  logic [7:0]     rsp_wdata,
    input  logic           rsp_load,
    input  logic [RIW-1:0] rsp_len,
    output logic           pkt_valid,
    output logic [LW-1:0]  pkt_len,
    input  logic [OAW-1:0] pkt_rd_addr,
    output logic [7:0]     pkt_rd_data
);
    logic [7:0]    b_q, ctl_q, sr_q, new_b;
    logic [LW-1:0] out_count;
    logic [7:0]    rsp_byte;
    logic          pending, last_one, go;
    eval_t         res;

    // Merge a host write, keeping the controller-owned request bit.
    always_comb begin
        new_b = pb_wr ? pb_wdata : b_q;
        new_b[REQ_BIT] = b_q[REQ_BIT];
    end

    assign go = pb_wr | rsp_load;

    hs_eval u_eval (
        .go          (go),
        .old_b       (b_q),
        .new_b       (new_b),
        .dir_send    (ctl_q[DIR_BIT]),
        .pending     (pending),
        .last_one    (last_one),
        .out_room    (out_count < LW'(OUT_DEPTH)),
        .out_nonempty(out_count != '0),
        .res         (res)
    );

    hs_out_buf #(.DEPTH(OUT_DEPTH), .W(8)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (res.append),
        .din    (sr_q),
        .clear  (res.pkt),
        .count  (out_count),
        .rd_addr(pkt_rd_addr),
        .rd_data(pkt_rd_data)
    );

    hs_rsp_buf #(.DEPTH(RSP_DEPTH), .W(8)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (rsp_wr),
        .waddr   (rsp_addr),
        .wdata   (rsp_wdata),
        .load    (rsp_load),
        .len     (rsp_len),
        .adv     (res.adv),
        .cur_byte(rsp_byte),
        .pending (pending),
        .last_one(last_one)
    );

    // Port and auxiliary control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q   <= PB_RESET;
            ctl_q <= '0;
        end else begin
            if (go)     b_q   <= res.nb;
            if (ctl_wr) ctl_q <= ctl_wdata;
        end
    end

    // Shift register: a delivered response byte wins over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (res.adv) sr_q <= rsp_byte;
        else if (sr_wr)   sr_q <= sr_wdata;
    end

    // Flag: an event sets it, and a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sr_flag <= 1'b0;
        else if (res.flag || rsp_load)   sr_flag <= 1'b1;
        else if (sr_clr)                 sr_flag <= 1'b0;
    end

    // Packet strobe and length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid <= 1'b0;
            pkt_len   <= '0;
        end else begin
            pkt_valid <= res.pkt;
            if (res.pkt) pkt_len <= out_count;
        end
    end

    assign pb_rdata = b_q;
    assign sr_rdata = sr_q;

    // R4
    pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0 && out_count == '0));
    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res.append || res.adv) |=> sr_flag);
    // R7
    req_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res.adv && last_one) |=> pb_rdata[REQ_BIT]);
    // R8
    ack_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_wr && b_q[TIP_BIT] && pb_wdata[TIP_BIT] && (pb_wdata[ACK_BIT] != b_q[ACK_BIT]))
        |=> (pb_rdata[REQ_BIT] == $past(pb_wdata[ACK_BIT])));
endmodule

// File: tb/tb_hs_xfer_top.sv
module tb_hs_xfer_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       pb_wr = 0, ctl_wr = 0, sr_wr = 0, sr_clr = 0, rsp_wr = 0, rsp_load = 0;
    logic [7:0] pb_wdata = 0, ctl_wdata = 0, sr_wdata = 0, rsp_wdata = 0;
    logic [6:0] rsp_addr = 0;
    logic [7:0] rsp_len = 0;
    logic [3:0] pkt_rd_addr = 0;
    logic [7:0] pb_rdata, sr_rdata, pkt_rd_data;
    logic       sr_flag, pkt_valid;
    logic [4:0] pkt_len;
    int checks = 0, errors = 0;
    int exp_q[$];
    bit done = 0;

    always #10 clk = ~clk;

    hs_xfer_top dut (.*);

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic pbw(input logic [7:0] v);
        @(negedge clk); pb_wr = 1; pb_wdata = v;
        @(negedge clk); pb_wr = 0;
    endtask
    task automatic srw(input logic [7:0] v);
        @(negedge clk); sr_wr = 1; sr_wdata = v;
        @(negedge clk); sr_wr = 0;
    endtask
    task automatic ctlw(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 0;
    endtask
    task automatic clr();
        @(negedge clk); sr_clr = 1;
        @(negedge clk); sr_clr = 0;
    endtask
    task automatic rsp_put(input int a, input logic [7:0] v);
        @(negedge clk); rsp_wr = 1; rsp_addr = 7'(a); rsp_wdata = v;
        @(negedge clk); rsp_wr = 0;
    endtask
    task automatic commit(input int n);
        @(negedge clk); rsp_load = 1; rsp_len = 8'(n);
        @(negedge clk); rsp_load = 0;
    endtask
    task automatic peek(input int a, input logic [7:0] exp, input string tag);
        pkt_rd_addr = 4'(a); #1;
        check(pkt_rd_data == exp, tag, pkt_rd_data, exp);
    endtask

    // Monitor: pop the expected length on every packet strobe.
    always @(negedge clk) begin
        if (rst_n && pkt_valid) begin
            if (exp_q.size() == 0) check(0, "R4/R5 unexpected pkt", pkt_len, 0);
            else begin
                int e;
                e = exp_q.pop_front();
                check(pkt_len == 5'(e), "R4 pkt_len", pkt_len, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(pb_rdata == 8'h38, "R1 port reset", pb_rdata, 8'h38);
        check(sr_flag == 0 && pkt_valid == 0, "R1 flag/pkt reset", sr_flag, 0);
        check(sr_rdata == 0, "R1 sr reset", sr_rdata, 0);

        // R11: host cannot write the request bit
        pbw(8'h30);
        check(pb_rdata == 8'h38, "R11 req bit kept", pb_rdata, 8'h38);
        check(sr_flag == 0, "R11 no event", sr_flag, 0);

        // R8: idle acknowledge echo
        pbw(8'h28);
        check(pb_rdata == 8'h20, "R8 req follows ack low", pb_rdata, 8'h20);
        check(sr_flag == 1, "R8 flag", sr_flag, 1);
        clr();
        check(sr_flag == 0, "R12 clear", sr_flag, 0);
        pbw(8'h38);
        check(pb_rdata == 8'h38, "R8 req follows ack high", pb_rdata, 8'h38);
        clr();

        // R2/R10/R4: host sends two bytes
        ctlw(8'h10);
        srw(8'h5A);
        pbw(8'h18);
        check(sr_flag == 1, "R2 flag on append", sr_flag, 1);
        clr();
        srw(8'h77);
        pbw(8'h18);
        check(sr_flag == 0, "R10 no move on same pair", sr_flag, 0);
        srw(8'h5B);
        pbw(8'h08);
        exp_q.push_back(2);
        pbw(8'h38);
        check(sr_flag == 1, "R4 flag at end", sr_flag, 1);
        peek(0, 8'h5A, "R2 byte0");
        peek(1, 8'h5B, "R10 byte1 not 77");
        clr();

        // R3: seventeen edges, sixteen stored
        for (int i = 0; i < 16; i++) begin
            srw(8'(8'h40 + i));
            pbw((i % 2 == 0) ? 8'h18 : 8'h08);
        end
        clr();
        srw(8'h99);
        pbw(8'h18);
        check(sr_flag == 0, "R3 full no flag", sr_flag, 0);
        exp_q.push_back(16);
        pbw(8'h38);
        peek(15, 8'h4F, "R3 last stored");
        peek(0, 8'h40, "R3 first stored");
        clr();

        // R5: empty end of transfer
        ctlw(8'h00);
        pbw(8'h18);
        clr();
        pbw(8'h38);
        check(sr_flag == 1, "R5 flag on empty end", sr_flag, 1);
        clr();

        // R9/R6/R7: response delivery
        rsp_put(0, 8'h11); rsp_put(1, 8'h22); rsp_put(2, 8'h33);
        commit(3);
        check(pb_rdata == 8'h30, "R9 req announced", pb_rdata, 8'h30);
        check(sr_flag == 1, "R9 flag on commit", sr_flag, 1);
        clr();
        pbw(8'h18);
        check(sr_rdata == 8'h11, "R6 byte0", sr_rdata, 8'h11);
        check(sr_flag == 1, "R6 flag", sr_flag, 1);
        pbw(8'h08);
        check(sr_rdata == 8'h22, "R6 byte1", sr_rdata, 8'h22);
        check(pb_rdata == 8'h00, "R7 req still low", pb_rdata, 8'h00);
        pbw(8'h18);
        check(sr_rdata == 8'h33, "R6 byte2", sr_rdata, 8'h33);
        check(pb_rdata == 8'h18, "R7 req high at end", pb_rdata, 8'h18);
        clr();
        pbw(8'h08);
        check(sr_rdata == 8'h33 && sr_flag == 0, "R6 no pending no move", sr_rdata, 8'h33);
        pbw(8'h38);
        check(pb_rdata == 8'h38, "R7 idle no pending", pb_rdata, 8'h38);
        rsp_put(0, 8'h77); rsp_put(1, 8'h88);
        commit(2);
        check(pb_rdata == 8'h30, "R9 req on second commit", pb_rdata, 8'h30);
        pbw(8'h18);
        check(sr_rdata == 8'h77, "R9 index restarted", sr_rdata, 8'h77);

        // R12: set wins over clear in the same cycle
        @(negedge clk); sr_clr = 1; pb_wr = 1; pb_wdata = 8'h08;
        @(negedge clk); sr_clr = 0; pb_wr = 0;
        check(sr_flag == 1, "R12 set beats clear", sr_flag, 1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 missing pkt", exp_q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got=0 exp=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule